// File: doc/BRIEF.md
# Daisy-Chained Serial Audio Receiver

This block sits on the receive side of a serial audio input port. It is clocked by the bit clock. On each rising edge it samples the serial data line and uses the word clock to find word boundaries. It then assembles one left word and one right word into parallel form. The word clock can be inverted by a polarity control before any framing is done. Two framing modes are supported:

- **Pulse framing.** A short frame pulse on the word clock starts a frame. The left word follows it, and the right word follows the left word back to back.
- **Level framing.** The word-clock level selects the channel, and the most significant bit arrives on the edge where that level changes.

In pulse framing mode the block can also drive a forwarded copy of the incoming bit stream. This copy is delayed by exactly twice the selected word length. When it is wired to the data input of an identical block that shares the same bit and word clocks, the downstream block captures the next channel pair of the same frame. A chain of devices therefore splits one multichannel stream between them. The upstream source must place each downstream device's pair earlier in the stream, by two word lengths per hop.

The parallel output is a stream with a valid strobe and no ready signal. A serial audio line cannot be stalled, so there is no back-pressure. The consumer must take `left_word` and `right_word` in the cycle where `word_valid` is high; the words are then held until the next pair is published.

Top module: `audio_chain_rx`

## Requirements
- R1: With pulse framing selected (`dsp_mode`=1) and `dout_en`=1, `dout` after bit-clock edge m equals the `din` value sampled at edge m-2W+1. Here W is the word length, and a downstream device sampling `dout` at edge m sees the data from edge m-2W.
- R2: When `dout_en`=0, `dout` is held low in every cycle. Word capture is unaffected.
- R3: With level framing selected (`dsp_mode`=0), `dout` is held low whatever `dout_en` is.
- R4: The effective word clock is `lrclk` XOR `lr_pol`, and it is used in both framing modes. With `lr_pol`=1 the frame pulse is a low pulse, and a low level selects the left channel.
- R5: In pulse framing, the edge that first sees the effective word clock high (after it was low) is the frame edge. The left word's MSB is sampled on the next edge, and its W bits follow MSB first. The right word's W bits follow with no gap.
- R6: In level framing, an effective high level selects left and a low level selects right. Each word's MSB is sampled on the edge where the effective level changes. A pair is published only after a left word followed by a right word.
- R7: After the last right bit, `word_valid` is high for exactly one cycle, visible just after that bit's edge. The words are right-aligned with the upper bits zero. All outputs are zero after reset.
- R8: A new frame edge in pulse framing that arrives in the middle of a word restarts capture from the left MSB. The partial word is dropped and no pair is published for it. Forwarding on `dout` carries on with no gap.
- R9: `wlen_sel` selects the word length W: 00 gives 16 bits, 01 gives 20, 10 gives 24 and 11 gives 32. The forwarding delay becomes 2W (32, 40, 48 or 64 cycles).
- R10: A second instance fed from the first one's `dout`, sharing both clocks and all settings, captures the pair that the source sent in the 2W bits ending at the frame edge. It publishes that pair in the same cycle as the first instance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; every register samples on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrclk | input | 1 | Word clock / frame pulse |
| din | input | 1 | Serial audio data in |
| wlen_sel | input | 2 | Word length select (R9 encoding) |
| dsp_mode | input | 1 | 1 = pulse framing, 0 = level framing |
| lr_pol | input | 1 | 1 inverts the word clock before framing |
| dout_en | input | 1 | 1 enables the forwarded stream in pulse framing |
| dout | output | 1 | Forwarded, delayed serial data |
| left_word | output | MAX_WORD | Captured left word, right-aligned |
| right_word | output | MAX_WORD | Captured right word, right-aligned |
| word_valid | output | 1 | One-cycle strobe marking a new pair |

## Verification
The bench chains two instances and checks the timing of the forwarded stream bit by bit, on every cycle, across all four word lengths. A delay line that is off by one would fail this check, and so would a tap fixed at one length; in both cases the downstream device would also capture shifted or wrong words. A frame pulse is sent again after eight bits into a word. A design that does not restart would publish a pair made from the partial word, or would publish twice. The bench also checks that the stream stays low when forwarding is disabled and in level framing. It runs both framing modes with the polarity inverted; a design that ignored the polarity would swap the channels or never find a frame.

// File: rtl/achn_pkg.sv
package achn_pkg;

  typedef enum logic [1:0] {
    WL_16 = 2'b00,
    WL_20 = 2'b01,
    WL_24 = 2'b10,
    WL_32 = 2'b11
  } wlen_e;

  function automatic int unsigned wlen_bits(input wlen_e sel);
    int unsigned b;
    unique case (sel)
      WL_16:   b = 16;
      WL_20:   b = 20;
      WL_24:   b = 24;
      default: b = 32;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/achn_lr_frame.sv
module achn_lr_frame (
  input  logic clk,
  input  logic rst_n,
  input  logic lrclk,
  input  logic lr_pol,
  output logic lr_level,
  output logic lr_rise,
  output logic lr_change
);
  logic lr_prev;

  // polarity applied ahead of every framing decision
  assign lr_level  = lrclk ^ lr_pol;
  assign lr_rise   = lr_level & ~lr_prev;
  assign lr_change = lr_level ^ lr_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lr_prev <= 1'b0;
    else        lr_prev <= lr_level;
  end
endmodule

// File: rtl/achn_delay_line.sv
module achn_delay_line #(
  parameter int DMAX = 64,
  localparam int DW  = $clog2(DMAX + 1),
  localparam int IW  = $clog2(DMAX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          din,
  input  logic [DW-1:0] depth,
  input  logic          fwd_on,
  output logic          dout
);
  logic [DMAX-1:0] shreg;
  logic [IW-1:0]   tap_idx;

  // shifts in every cycle so the stream never stalls on a restart
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[DMAX-2:0], din};
  end

  assign tap_idx = IW'(depth - DW'(1));
  assign dout    = fwd_on & shreg[tap_idx];
endmodule

// File: rtl/achn_word_capture.sv
module achn_word_capture #(
  parameter int MAXW = 32,
  localparam int CW  = $clog2(MAXW + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            din,
  input  logic            dsp,
  input  logic            lr_level,
  input  logic            lr_rise,
  input  logic            lr_change,
  input  logic [CW-1:0]   wbits,
  output logic [MAXW-1:0] left_o,
  output logic [MAXW-1:0] right_o,
  output logic            valid_o
);
  logic            active;
  logic            chan;       // 0 left, 1 right
  logic            have_left;
  logic [CW-1:0]   cnt;
  logic [MAXW-2:0] sh;
  logic [MAXW-1:0] lstage;
  logic [MAXW-1:0] nxt;
  logic [CW-1:0]   last_idx;
  logic            word_done;

  assign nxt       = {sh, din};
  assign last_idx  = wbits - CW'(1);
  assign word_done = active && (cnt == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      chan      <= 1'b0;
      have_left <= 1'b0;
      cnt       <= '0;
      sh        <= '0;
      lstage    <= '0;
      left_o    <= '0;
      right_o   <= '0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (dsp) begin
        if (lr_rise) begin
          // frame edge: MSB of left word comes on the next edge
          active <= 1'b1;
          chan   <= 1'b0;
          cnt    <= '0;
          sh     <= '0;
        end else if (word_done) begin
          if (!chan) begin
            lstage <= nxt;
            chan   <= 1'b1;
            cnt    <= '0;
            sh     <= '0;
          end else begin
            left_o  <= lstage;
            right_o <= nxt;
            valid_o <= 1'b1;
            active  <= 1'b0;
          end
        end else if (active) begin
          cnt <= cnt + CW'(1);
          sh  <= nxt[MAXW-2:0];
        end
      end else begin
        if (lr_change) begin
          // level change: this edge carries the MSB
          active <= 1'b1;
          chan   <= ~lr_level;
          cnt    <= CW'(1);
          sh     <= {{(MAXW-2){1'b0}}, din};
          if (lr_level) have_left <= 1'b0;
        end else if (word_done) begin
          active <= 1'b0;
          if (!chan) begin
            lstage    <= nxt;
            have_left <= 1'b1;
          end else begin
            if (have_left) begin
              left_o  <= lstage;
              right_o <= nxt;
              valid_o <= 1'b1;
            end
            have_left <= 1'b0;
          end
        end else if (active) begin
          cnt <= cnt + CW'(1);
          sh  <= nxt[MAXW-2:0];
        end
      end
    end
  end

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt < wbits));

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp && lr_rise) |=> (active && !chan && cnt == '0 && !valid_o));
endmodule

// File: rtl/audio_chain_rx.sv
module audio_chain_rx #(
  parameter int MAX_WORD = 32,
  localparam int CW   = $clog2(MAX_WORD + 1),
  localparam int DMAX = 2 * MAX_WORD,
  localparam int DW   = CW + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lrclk,
  input  logic                din,
  input  logic [1:0]          wlen_sel,
  input  logic                dsp_mode,
  input  logic                lr_pol,
  input  logic                dout_en,
  output logic                dout,
  output logic [MAX_WORD-1:0] left_word,
  output logic [MAX_WORD-1:0] right_word,
  output logic                word_valid
);
  import achn_pkg::*;

  logic          lr_level, lr_rise, lr_change;
  logic [CW-1:0] wbits;
  logic [DW-1:0] depth;
  logic          fwd_on;

  assign wbits  = CW'(wlen_bits(wlen_e'(wlen_sel)));
  assign depth  = {wbits, 1'b0};
  assign fwd_on = dsp_mode & dout_en;

  achn_lr_frame u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .lrclk     (lrclk),
    .lr_pol    (lr_pol),
    .lr_level  (lr_level),
    .lr_rise   (lr_rise),
    .lr_change (lr_change)
  );

  achn_delay_line #(.DMAX(DMAX)) u_dly (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (din),
    .depth  (depth),
    .fwd_on (fwd_on),
    .dout   (dout)
  );

  achn_word_capture #(.MAXW(MAX_WORD)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .din       (din),
    .dsp       (dsp_mode),
    .lr_level  (lr_level),
    .lr_rise   (lr_rise),
    .lr_change (lr_change),
    .wbits     (wbits),
    .left_o    (left_word),
    .right_o   (right_word),
    .valid_o   (word_valid)
  );

  // R2
  dout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dsp_mode && dout_en) |-> !dout);
endmodule

// File: tb/sim_audio_chain_rx.sv
`timescale 1ns/1ps
module sim_audio_chain_rx;
  logic clk = 1'b0, rst_n = 1'b0, lrclk = 1'b0, din = 1'b0;
  logic dsp_mode = 1'b1, lr_pol = 1'b0, dout_en = 1'b1;
  logic [1:0] wlen_sel = 2'b00;
  logic d0, d1, v0, v1;
  logic [31:0] l0w, r0w, l1w, r1w;

  always #2 clk = ~clk;

  audio_chain_rx u0 (.clk(clk), .rst_n(rst_n), .lrclk(lrclk), .din(din),
    .wlen_sel(wlen_sel), .dsp_mode(dsp_mode), .lr_pol(lr_pol), .dout_en(dout_en),
    .dout(d0), .left_word(l0w), .right_word(r0w), .word_valid(v0));

  audio_chain_rx u1 (.clk(clk), .rst_n(rst_n), .lrclk(lrclk), .din(d0),
    .wlen_sel(wlen_sel), .dsp_mode(dsp_mode), .lr_pol(lr_pol), .dout_en(dout_en),
    .dout(d1), .left_word(l1w), .right_word(r1w), .word_valid(v1));

  // {wlen_sel, lr_pol, left A, right A, left B, right B}
  localparam logic [130:0] VEC [5] = '{
    {2'b00, 1'b0, 32'hFFFF_A5C3, 32'h0000_3C96, 32'h0000_F00F, 32'h0000_1248},
    {2'b01, 1'b1, 32'h000F_1234, 32'h0008_0001, 32'h0007_FFFE, 32'h000A_5A5A},
    {2'b10, 1'b0, 32'h00C0_FFEE, 32'h0012_3456, 32'h0080_0001, 32'h007F_FF00},
    {2'b11, 1'b1, 32'hDEAD_BEEF, 32'h8000_0001, 32'h0123_4567, 32'hFEDC_BA98},
    {2'b11, 1'b0, 32'hFFFF_FFFF, 32'h0000_0000, 32'h5555_AAAA, 32'hAAAA_5555}
  };

  int checks = 0, failures = 0;
  bit hist [8192];
  int n = 0;
  int mon_err = 0, mon_cnt = 0;
  int vc0 = 0, vc1 = 0, vt0 = 0, vt1 = 0;
  logic [31:0] gl0, gr0, gl1, gr1;
  bit done = 0;

  function automatic int wbits(input logic [1:0] s);
    case (s)
      2'b00:   return 16;
      2'b01:   return 20;
      2'b10:   return 24;
      default: return 32;
    endcase
  endfunction

  function automatic logic [31:0] mask(input logic [31:0] v, input int w);
    return v & (32'hFFFF_FFFF >> (32 - w));
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic lr, input logic d);
    int dd;
    logic ex;
    lrclk = lr;
    din   = d;
    @(posedge clk);
    #1;
    hist[n % 8192] = d;
    n++;
    dd = 2 * wbits(wlen_sel);
    if (n >= dd) begin
      ex = (dsp_mode && dout_en) ? hist[(n - dd) % 8192] : 1'b0;
      mon_cnt++;
      if (d0 !== ex) mon_err++;
    end
    if (v0 === 1'b1) begin vc0++; vt0 = n; gl0 = l0w; gr0 = r0w; end
    if (v1 === 1'b1) begin vc1++; vt1 = n; gl1 = l1w; gr1 = r1w; end
  endtask

  task automatic clear_obs();
    vc0 = 0; vc1 = 0; vt0 = 0; vt1 = 0; mon_err = 0; mon_cnt = 0;
  endtask

  task automatic send_bits(input logic lr, input logic [31:0] v, input int w);
    for (int i = w - 1; i >= 0; i--) tick(lr, v[i]);
  endtask

  // downstream pair ends on the frame edge; local pair follows it
  task automatic send_dsp(input logic [31:0] la, input logic [31:0] ra,
                          input logic [31:0] lb, input logic [31:0] rb, output int nr);
    int w;
    logic idle;
    w = wbits(wlen_sel);
    idle = lr_pol;
    send_bits(idle, lb, w);
    for (int i = w - 1; i >= 1; i--) tick(idle, rb[i]);
    tick(~idle, rb[0]);
    nr = n;
    send_bits(idle, la, w);
    send_bits(idle, ra, w);
    repeat (4) tick(idle, 1'b0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog R1 act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int nr, w, nl;
    logic [31:0] la, ra, lb, rb;
    repeat (3) @(posedge clk);
    #1;
    chk(d0 == 0 && v0 == 0 && l0w == 0 && r0w == 0, "R7 reset state",
        {d0, v0, l0w}, 0);
    @(negedge clk) rst_n = 1'b1;

    // vector table: pulse framing, chained pair, every word length
    for (int k = 0; k < 5; k++) begin
      {wlen_sel, lr_pol, la, ra, lb, rb} = VEC[k];
      dsp_mode = 1'b1; dout_en = 1'b1;
      w = wbits(wlen_sel);
      tick(lr_pol, 1'b0); tick(lr_pol, 1'b0);
      clear_obs();
      send_dsp(la, ra, lb, rb, nr);
      chk(vc0 == 1, "R5 one pair per frame", vc0, 1);
      chk(gl0 == mask(la, w) && gr0 == mask(ra, w), "R5 R9 R4 local words",
          {gl0, gr0}, {mask(la, w), mask(ra, w)});
      chk(vt0 == nr + 2 * w, "R7 strobe timing", vt0, nr + 2 * w);
      chk(vc1 == 1 && gl1 == mask(lb, w) && gr1 == mask(rb, w) && vt1 == vt0,
          "R10 downstream pair", {gl1, gr1}, {mask(lb, w), mask(rb, w)});
      chk(mon_err == 0 && mon_cnt > 0, "R1 R9 forward delay", mon_err, 0);
    end

    // R2: forwarding disabled in pulse framing
    wlen_sel = 2'b00; lr_pol = 1'b0; dsp_mode = 1'b1; dout_en = 1'b0;
    tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    clear_obs();
    send_dsp(32'hFFFF, 32'hFFFF, 32'hFFFF, 32'hFFFF, nr);
    chk(mon_err == 0 && mon_cnt > 0, "R2 dout low when disabled", mon_err, 0);
    chk(vc0 == 1 && gl0 == 32'hFFFF, "R2 capture unaffected", gl0, 32'hFFFF);

    // R3 R6 R4: level framing, both polarities
    for (int p = 0; p < 2; p++) begin
      dsp_mode = 1'b0; dout_en = 1'b1; wlen_sel = 2'b10;
      lr_pol = p[0];
      tick(lr_pol, 1'b1); tick(lr_pol, 1'b1);
      clear_obs();
      send_bits(~lr_pol, 32'h00A1_B2C3, 24);
      send_bits(lr_pol, 32'h005D_4E3F, 24);
      nl = n;
      repeat (3) tick(lr_pol, 1'b1);
      chk(vc0 == 1 && gl0 == 32'h00A1_B2C3 && gr0 == 32'h005D_4E3F,
          "R6 R4 level framing words", {gl0, gr0}, {32'h00A1_B2C3, 32'h005D_4E3F});
      chk(vt0 == nl, "R6 level framing strobe", vt0, nl);
      chk(mon_err == 0 && mon_cnt > 0, "R3 dout low in level framing", mon_err, 0);
    end

    // R8: frame edge arrives eight bits into the left word
    dsp_mode = 1'b1; dout_en = 1'b1; wlen_sel = 2'b00; lr_pol = 1'b0;
    tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    clear_obs();
    tick(1'b1, 1'b0);
    for (int i = 0; i < 8; i++) tick(1'b0, i[0]);
    tick(1'b1, 1'b1);
    nr = n;
    send_bits(1'b0, 32'h0000_6C39, 16);
    send_bits(1'b0, 32'h0000_9AE1, 16);
    repeat (4) tick(1'b0, 1'b0);
    chk(vc0 == 1, "R8 single pair after restart", vc0, 1);
    chk(gl0 == 32'h6C39 && gr0 == 32'h9AE1, "R8 restart words",
        {gl0, gr0}, {32'h6C39, 32'h9AE1});
    chk(vt0 == nr + 32, "R8 restart strobe timing", vt0, nr + 32);
    chk(mon_err == 0 && mon_cnt > 0, "R8 R1 forwarding without gap", mon_err, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule